// File: doc/BRIEF.md
# Executable Image Segment Loader

This engine brings a program image from a sector-addressed disk into memory without a processor running a boot routine. After a start pulse it fetches the first 4096 bytes of the image into a fixed scratch region. It then checks the 4-byte identification at the head of that region and refuses the image if those bytes are wrong.

For an image that passes the check, the engine reads a table of loadable segments one entry at a time. Each entry gives a destination address, a byte offset into the image, a file size and a memory size. The engine copies every segment with whole-sector reads and clears the part of memory that the file does not cover. When every entry has been handled it raises done and presents the entry address taken from the header.

Sector reads are deliberately coarse. A segment's destination is rounded down to a sector boundary, so bytes just before and just after the segment can be overwritten with neighbouring image data. Image sector n lives at disk sector n+1, because disk sector 0 is reserved.

Top module: `ldr_engine`

## Requirements
- R1: The first header word, read little-endian, must equal 0x464C457F (bytes 7F 45 4C 46). If it does not, err_o rises, done_o stays low and no descriptor is processed.
- R2: After start_i, the 4096-byte header is read from disk sectors 1 to 8. Disk word k is written to SCRATCH_ADDR+4k with all byte enables set. This happens before any segment write.
- R3: When done_o is high, entry_o equals header word 6 (byte offset 24, little-endian) of the current run.
- R4: A segment's reads start at va rounded down to a multiple of 512. The first disk sector is (offset − va mod 512)/512 + 1, so sector 0 is never requested.
- R5: Consecutive whole sectors go to consecutive 512-byte destination blocks. Reading continues while the block start is below va+filesz. With filesz 0 and an unaligned va, exactly one sector is still read.
- R6: When memsz > filesz, bytes va+filesz up to va+memsz−1 are written with zero. This is done one word-aligned write per cycle, where byte-enable bit b covers byte address+b. Only bytes in that range are enabled, and the clearing follows the segment's reads.
- R7: Descriptors are handled in table order, from index 0 up to desc_cnt_i−1. A descriptor whose memsz is 0 causes no disk request and no memory write.
- R8: done_o and err_o are never high together. Each holds until the next start_i. Every disk request is a single-cycle pulse, and no request or write occurs while done_o is high.
- R9: Disk word k of a sector is written unchanged, with all byte enables set, to the sector's destination plus 4k. Every memory write is word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load; ignored while busy |
| desc_cnt_i | input | IW | Number of descriptors in the table |
| tbl_idx_o | output | IW | Descriptor index being read |
| tbl_va_i | input | AW | Destination address of the indexed descriptor |
| tbl_off_i | input | AW | Byte offset in the image |
| tbl_fsz_i | input | AW | Bytes taken from the image |
| tbl_msz_i | input | AW | Bytes occupied in memory |
| dsk_req_o | output | 1 | One-cycle sector read request |
| dsk_lba_o | output | LW | Sector number of the request |
| dsk_vld_i | input | 1 | Data word valid from disk |
| dsk_dat_i | input | 32 | Data word from disk |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Byte enables |
| entry_o | output | AW | Entry address of the loaded image |
| done_o | output | 1 | Load finished |
| err_o | output | 1 | Identification check failed |

## Verification
The properties in the checker hold on every cycle and cover the following:
- done and error are exclusive;
- error holds until the next start;
- disk requests are single pulses that never address sector 0;
- every write is aligned, and any write with partial byte enables carries zero data;
- the engine stays quiet while done is high.

The bench's scenarios cover what needs knowledge of the image and the table:
- the exact write stream for unaligned segment starts and trailing sector overshoot;
- zero-filling that partly overwrites that overshoot;
- a zero-length file part that still pulls one sector;
- skipped empty descriptors;
- rejection of a bad identification word;
- recapture of the entry word on a second run.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int WORD_W = 32;
  localparam int WORD_B = WORD_W / 8;
  localparam logic [WORD_W-1:0] IMG_MAGIC = 32'h464C_457F;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR_GO,
    ST_HDR_WAIT,
    ST_CHECK,
    ST_DESC,
    ST_SEG_CHK,
    ST_SEG_GO,
    ST_SEG_WAIT,
    ST_ZF_CHK,
    ST_ZF_WAIT,
    ST_NEXT,
    ST_DONE,
    ST_ERR
  } ldr_state_e;
endpackage

// File: rtl/ldr_sect_rd.sv
module ldr_sect_rd #(
  parameter int AW  = 32,
  parameter int LW  = 28,
  parameter int WPS = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      go_i,
  input  logic [LW-1:0]             lba_i,
  input  logic [AW-1:0]             dst_i,
  output logic                      dsk_req_o,
  output logic [LW-1:0]             dsk_lba_o,
  input  logic                      dsk_vld_i,
  input  logic [ldr_pkg::WORD_W-1:0] dsk_dat_i,
  output logic                      wr_o,
  output logic [AW-1:0]             wr_addr_o,
  output logic [ldr_pkg::WORD_W-1:0] wr_data_o,
  output logic [$clog2(WPS)-1:0]    widx_o,
  output logic                      fin_o
);
  localparam int WCW = $clog2(WPS);
  localparam int SH  = $clog2(ldr_pkg::WORD_B);

  logic           act_q, req_q, last;
  logic [WCW-1:0] wcnt_q;
  logic [AW-1:0]  base_q;
  logic [LW-1:0]  lba_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      req_q  <= 1'b0;
      wcnt_q <= '0;
      base_q <= '0;
      lba_q  <= '0;
    end else begin
      req_q <= 1'b0;
      if (go_i && !act_q) begin
        act_q  <= 1'b1;
        req_q  <= 1'b1;
        base_q <= dst_i;
        lba_q  <= lba_i;
        wcnt_q <= '0;
      end else if (act_q && dsk_vld_i) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (last) act_q <= 1'b0;
      end
    end
  end

  assign last      = (wcnt_q == WCW'(WPS - 1));
  assign dsk_req_o = req_q;
  assign dsk_lba_o = lba_q;
  assign wr_o      = act_q & dsk_vld_i;
  assign wr_addr_o = base_q + (AW'(wcnt_q) << SH);
  assign wr_data_o = dsk_dat_i;
  assign widx_o    = wcnt_q;
  assign fin_o     = wr_o & last;
endmodule

// File: rtl/ldr_zfill.sv
module ldr_zfill #(
  parameter int AW = 32,
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [BW-1:0] be_o,
  output logic          fin_o
);
  logic          act_q, last;
  logic [AW-1:0] w_q, lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      w_q   <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (go_i && !act_q) begin
      act_q <= 1'b1;
      w_q   <= lo_i & ~AW'(BW - 1);
      lo_q  <= lo_i;
      hi_q  <= hi_i;
    end else if (act_q) begin
      w_q <= w_q + AW'(BW);
      if (last) act_q <= 1'b0;
    end
  end

  assign last = (w_q + AW'(BW)) >= hi_q;

  for (genvar b = 0; b < BW; b++) begin : g_be
    assign be_o[b] = act_q && ((w_q + AW'(b)) >= lo_q) && ((w_q + AW'(b)) < hi_q);
  end

  assign wr_o   = act_q;
  assign addr_o = w_q;
  assign fin_o  = act_q & last;
endmodule

// File: rtl/ldr_engine.sv
module ldr_engine #(
  parameter int          AW           = 32,
  parameter int          LW           = 28,
  parameter int          IW           = 4,
  parameter int          SECT_BYTES   = 512,
  parameter int          HDR_BYTES    = 4096,
  parameter int          ENTRY_WORD   = 6,
  parameter logic [31:0] SCRATCH_ADDR = 32'h0001_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] desc_cnt_i,
  output logic [IW-1:0] tbl_idx_o,
  input  logic [AW-1:0] tbl_va_i,
  input  logic [AW-1:0] tbl_off_i,
  input  logic [AW-1:0] tbl_fsz_i,
  input  logic [AW-1:0] tbl_msz_i,
  output logic          dsk_req_o,
  output logic [LW-1:0] dsk_lba_o,
  input  logic          dsk_vld_i,
  input  logic [31:0]   dsk_dat_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  output logic [AW-1:0] entry_o,
  output logic          done_o,
  output logic          err_o
);
  import ldr_pkg::*;

  localparam int WPS       = SECT_BYTES / WORD_B;
  localparam int HDR_SECTS = HDR_BYTES / SECT_BYTES;
  localparam int SB        = $clog2(SECT_BYTES);
  localparam int WCW       = $clog2(WPS);
  localparam int HCW       = $clog2(HDR_SECTS + 1);
  localparam logic [AW-1:0] SMASK = AW'(SECT_BYTES - 1);

  ldr_state_e         st_q;
  logic [IW-1:0]      idx_q;
  logic [HCW-1:0]     hsec_q;
  logic [LW-1:0]      lba_q;
  logic [AW-1:0]      dst_q, end_q, z_lo_q, z_hi_q, entry_q;
  logic [WORD_W-1:0]  magic_q;
  logic               done_q, err_q;

  logic               sr_go, sr_wr, sr_fin;
  logic [AW-1:0]      sr_addr;
  logic [WORD_W-1:0]  sr_data;
  logic [WCW-1:0]     sr_widx;
  logic               zf_go, zf_wr, zf_fin;
  logic [AW-1:0]      zf_addr;
  logic [WORD_B-1:0]  zf_be;

  assign sr_go = (st_q == ST_HDR_GO) || (st_q == ST_SEG_GO);
  assign zf_go = (st_q == ST_ZF_CHK) && (z_hi_q > z_lo_q);

  ldr_sect_rd #(.AW(AW), .LW(LW), .WPS(WPS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (sr_go),
    .lba_i     (lba_q),
    .dst_i     (dst_q),
    .dsk_req_o (dsk_req_o),
    .dsk_lba_o (dsk_lba_o),
    .dsk_vld_i (dsk_vld_i),
    .dsk_dat_i (dsk_dat_i),
    .wr_o      (sr_wr),
    .wr_addr_o (sr_addr),
    .wr_data_o (sr_data),
    .widx_o    (sr_widx),
    .fin_o     (sr_fin)
  );

  ldr_zfill #(.AW(AW), .BW(WORD_B)) u_zf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (zf_go),
    .lo_i   (z_lo_q),
    .hi_i   (z_hi_q),
    .wr_o   (zf_wr),
    .addr_o (zf_addr),
    .be_o   (zf_be),
    .fin_o  (zf_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      hsec_q  <= '0;
      lba_q   <= '0;
      dst_q   <= '0;
      end_q   <= '0;
      z_lo_q  <= '0;
      z_hi_q  <= '0;
      entry_q <= '0;
      magic_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            hsec_q <= '0;
            idx_q  <= '0;
            dst_q  <= AW'(SCRATCH_ADDR);
            lba_q  <= LW'(1);
            st_q   <= ST_HDR_GO;
          end
        end
        ST_HDR_GO: st_q <= ST_HDR_WAIT;
        ST_HDR_WAIT: begin
          if (sr_wr && hsec_q == '0) begin
            if (sr_widx == WCW'(0))          magic_q <= sr_data;
            if (sr_widx == WCW'(ENTRY_WORD)) entry_q <= AW'(sr_data);
          end
          if (sr_fin) begin
            if (hsec_q == HCW'(HDR_SECTS - 1)) begin
              st_q <= ST_CHECK;
            end else begin
              hsec_q <= hsec_q + 1'b1;
              dst_q  <= dst_q + AW'(SECT_BYTES);
              lba_q  <= lba_q + 1'b1;
              st_q   <= ST_HDR_GO;
            end
          end
        end
        ST_CHECK: begin
          if (magic_q == IMG_MAGIC) begin
            st_q <= ST_DESC;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_ERR;
          end
        end
        ST_DESC: begin
          if (idx_q == desc_cnt_i) begin
            done_q <= 1'b1;
            st_q   <= ST_DONE;
          end else if (tbl_msz_i == '0) begin
            idx_q <= idx_q + 1'b1;
          end else begin
            dst_q  <= tbl_va_i & ~SMASK;
            lba_q  <= LW'((tbl_off_i - (tbl_va_i & SMASK)) >> SB) + LW'(1);
            end_q  <= tbl_va_i + tbl_fsz_i;
            z_lo_q <= tbl_va_i + tbl_fsz_i;
            z_hi_q <= tbl_va_i + tbl_msz_i;
            st_q   <= ST_SEG_CHK;
          end
        end
        ST_SEG_CHK: st_q <= (dst_q < end_q) ? ST_SEG_GO : ST_ZF_CHK;
        ST_SEG_GO:  st_q <= ST_SEG_WAIT;
        ST_SEG_WAIT: begin
          if (sr_fin) begin
            dst_q <= dst_q + AW'(SECT_BYTES);
            lba_q <= lba_q + 1'b1;
            st_q  <= ST_SEG_CHK;
          end
        end
        ST_ZF_CHK: st_q <= zf_go ? ST_ZF_WAIT : ST_NEXT;
        ST_ZF_WAIT: if (zf_fin) st_q <= ST_NEXT;
        ST_NEXT: begin
          idx_q <= idx_q + 1'b1;
          st_q  <= ST_DESC;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o    = sr_wr | zf_wr;
  assign mem_addr_o  = zf_wr ? zf_addr : sr_addr;
  assign mem_wdata_o = zf_wr ? '0 : sr_data;
  assign mem_be_o    = zf_wr ? zf_be : '1;
  assign tbl_idx_o   = idx_q;
  assign entry_o     = entry_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
endmodule

module ldr_engine_chk #(
  parameter int AW = 32,
  parameter int LW = 28
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          dsk_req_o,
  input logic [LW-1:0] dsk_lba_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic [3:0]    mem_be_o,
  input logic          done_o,
  input logic          err_o
);
  AST_LBA_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsk_req_o |-> dsk_lba_o != '0);                                  // R4
  AST_PARTIAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_be_o != 4'hF |-> mem_wdata_o == '0);             // R6
  AST_BE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_be_o != 4'h0);                                  // R6
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));                                             // R8
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsk_req_o |=> !dsk_req_o);                                       // R8
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);                                    // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o && !dsk_req_o);                             // R8
  AST_WORD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[1:0] == 2'b00);                          // R9
endmodule

bind ldr_engine ldr_engine_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .dsk_req_o   (dsk_req_o),
  .dsk_lba_o   (dsk_lba_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_be_o    (mem_be_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/ldr_engine_test.sv
module ldr_engine_test;
  localparam int AW = 32;
  localparam int LW = 28;
  localparam int IW = 4;
  localparam logic [31:0] SCRATCH = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] desc_cnt = '0;
  logic [IW-1:0] tbl_idx;
  logic [AW-1:0] tbl_va, tbl_off, tbl_fsz, tbl_msz;
  logic          dsk_req;
  logic [LW-1:0] dsk_lba;
  logic          dsk_vld = 1'b0;
  logic [31:0]   dsk_dat = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_be;
  logic [AW-1:0] entry;
  logic          done, err;

  always #4 clk = ~clk;

  logic [31:0] t_va [16];
  logic [31:0] t_off[16];
  logic [31:0] t_fsz[16];
  logic [31:0] t_msz[16];
  assign tbl_va  = t_va [tbl_idx];
  assign tbl_off = t_off[tbl_idx];
  assign tbl_fsz = t_fsz[tbl_idx];
  assign tbl_msz = t_msz[tbl_idx];

  ldr_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_cnt_i(desc_cnt),
    .tbl_idx_o(tbl_idx), .tbl_va_i(tbl_va), .tbl_off_i(tbl_off),
    .tbl_fsz_i(tbl_fsz), .tbl_msz_i(tbl_msz),
    .dsk_req_o(dsk_req), .dsk_lba_o(dsk_lba), .dsk_vld_i(dsk_vld), .dsk_dat_i(dsk_dat),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be),
    .entry_o(entry), .done_o(done), .err_o(err)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  exp_t        e;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] magic_img = 32'h464C_457F;
  logic [31:0] entry_img = 32'h0010_000C;

  function automatic logic [31:0] img_word(int k);
    if (k == 0) return magic_img;
    if (k == 6) return entry_img;
    return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic push(input logic [31:0] a, d, input logic [3:0] b, input string t);
    exp_t x;
    x.addr = a; x.data = d; x.be = b; x.tag = t;
    exp_q.push_back(x);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_hdr();
    for (int k = 0; k < 1024; k++) push(SCRATCH + 32'(4 * k), img_word(k), 4'hF, "R2");
  endtask

  task automatic push_seg(input logic [31:0] va, off, fsz, msz);
    logic [31:0] pa, oal, fend, w, zhi;
    logic [3:0]  be;
    int          wb;
    if (msz == 0) return;   // R7 skipped descriptor
    pa   = va & ~32'h1FF;
    oal  = off - (va & 32'h1FF);
    fend = va + fsz;
    wb   = int'(oal >> 9) * 128;
    while (pa < fend) begin
      for (int k = 0; k < 128; k++) push(pa + 32'(4 * k), img_word(wb + k), 4'hF, "R5");
      pa += 512;
      wb += 128;
    end
    zhi = va + msz;
    if (zhi > fend) begin
      w = fend & ~32'h3;
      while (w < zhi) begin
        for (int b = 0; b < 4; b++) be[b] = ((w + 32'(b)) >= fend) && ((w + 32'(b)) < zhi);
        push(w, 32'h0, be, "R6");
        w += 4;
      end
    end
  endtask

  // disk model: one sector of 128 words per request, with idle gaps
  initial begin
    int g;
    g = 0;
    forever begin
      @(posedge clk); #1;
      if (rst_n && dsk_req) begin
        int base;
        int k;
        base = (int'(dsk_lba) - 1) * 128;
        k = 0;
        while (k < 128) begin
          g++;
          if (g % 7 == 3) dsk_vld = 1'b0;
          else begin
            dsk_vld = 1'b1;
            dsk_dat = img_word(base + k);
            k++;
          end
          @(posedge clk); #1;
        end
        dsk_vld = 1'b0;
      end
    end
  end

  // monitor: compare every memory write with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_we) begin
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R7 unexpected write: actual addr %h data %h be %h expected none",
                   mem_addr, mem_wdata, mem_be);
        end else begin
          e = exp_q.pop_front();
          if (mem_addr !== e.addr || mem_wdata !== e.data || mem_be !== e.be) begin
            n_bad++;
            $display("FAIL %s: actual addr %h data %h be %h expected addr %h data %h be %h",
                     e.tag, mem_addr, mem_wdata, mem_be, e.addr, e.data, e.be);
          end
        end
      end
    end
  end

  task automatic run_load(input bit exp_err, input string tag);
    int cyc;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    while (!(done || err) && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: watchdog, actual no completion expected completion", tag);
    end
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(exp_err ? "R1 err" : "R8 done", {30'd0, err, done}, exp_err ? 32'd2 : 32'd1);
    chk("R7 all writes seen", 32'(exp_q.size()), 32'd0);
    if (!exp_err) chk("R3 entry", entry, entry_img);
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R8: global watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_va[0] = 32'h0010_73E0; t_off[0] = 32'h0000_73E0; t_fsz[0] = 32'h79E; t_msz[0] = 32'h7E4;
    t_va[1] = 32'h0050_0000; t_off[1] = 32'h0000_9000; t_fsz[1] = 32'h400; t_msz[1] = 32'h0;
    t_va[2] = 32'h0010_0000; t_off[2] = 32'h0000_1000; t_fsz[2] = 32'h200; t_msz[2] = 32'h200;
    t_va[3] = 32'h0020_0010; t_off[3] = 32'h0000_2010; t_fsz[3] = 32'h0;   t_msz[3] = 32'h9;
    t_va[4] = 32'h0030_0101; t_off[4] = 32'h0000_3101; t_fsz[4] = 32'h100; t_msz[4] = 32'h102;
    for (int i = 5; i < 16; i++) begin
      t_va[i] = '0; t_off[i] = '0; t_fsz[i] = '0; t_msz[i] = '0;
    end

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset done/err", {30'd0, err, done}, 32'd0);
    chk("R8 reset idle", {30'd0, dsk_req, mem_we}, 32'd0);

    // R1 bad identification word: header only, then error
    magic_img = 32'h464C_4580;
    desc_cnt  = 4'd3;
    push_hdr();
    run_load(1'b1, "R1");
    chk("R1 done low", {31'd0, done}, 32'd0);

    // R2..R7 good image, five descriptors in order
    magic_img = 32'h464C_457F;
    desc_cnt  = 4'd5;
    push_hdr();
    for (int i = 0; i < 5; i++) push_seg(t_va[i], t_off[i], t_fsz[i], t_msz[i]);
    run_load(1'b0, "R5");

    // R3 second run, empty table, new entry word
    entry_img = 32'h0020_4000;
    desc_cnt  = 4'd0;
    push_hdr();
    run_load(1'b0, "R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule